// File: doc/BRIEF.md
# Truth-Table Mask Logic Unit

This unit combines two mask words bit by bit using any one of the sixteen possible two-input Boolean functions. A 4-bit truth-table code chooses the function. Each bit of the code is the result for one combination of the two operand bits. A named-operation mode covers the common helpers: clear, set, copy, invert, and-not, or-not, xor-not and the plain logic functions. It converts a small operation index into the matching truth-table code, so callers do not need to build codes themselves.

Requests and results travel over valid/ready streams. A request is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. Its result is held in one output register and appears on the next edge with `out_valid` high. The result stays there, unchanged, until a rising edge where `out_valid` and `out_ready` are both high.

`in_ready` is high when the output register is empty or is being drained in the same cycle. Back-pressure therefore passes straight through to the input with no additional storage. A continuous stream with `out_ready` held high moves one request per clock.

Top module: `mask_tt_unit`

## Requirements
- R1: A synchronous active-high `rst` drives `out_valid` low and `out_result` to all zeros, starting at the first rising edge where `rst` is sampled high.
- R2: With `in_named` = 0, every result bit i equals `in_code[{in_src1[i], in_src2[i]}]`. Code bit 0 applies when both operand bits are 0. Bit 1 applies when the src2 bit is 1 and the src1 bit is 0. Bit 2 applies when the src1 bit is 1 and the src2 bit is 0. Bit 3 applies when both operand bits are 1.
- R3: Raw code 4'h0 gives an all-zero result and raw code 4'hF gives an all-ones result, whatever the operands are.
- R4: With `in_named` = 1, `in_code` selects a named operation (a = src1, b = src2). The indices are: 0 clear, 1 set, 2 copy a, 3 copy b, 4 not a, 5 not b, 6 a&~b, 7 a|~b, 8 a^~b, 9 a&b, 10 a|b, 11 a^b.
- R5: With `in_named` = 1, indices 12 to 15 produce an all-zero result.
- R6: A request accepted on one rising edge shows its result on `out_result`, with `out_valid` high, after the next rising edge. That is a latency of one clock.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_result` stay unchanged and `in_ready` is low.
- R8: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. If no request is accepted on an edge where the output is empty or being drained, `out_valid` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit can accept a request this cycle |
| in_named | input | 1 | 0: `in_code` is a raw truth table; 1: `in_code` is a named-operation index |
| in_code | input | 4 | Truth table or named-operation index |
| in_src1 | input | W | First mask operand (a) |
| in_src2 | input | W | Second mask operand (b) |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result this cycle |
| out_result | output | W | Registered result word |

## Verification
The hardest case to reach from the ports is the edge on which a held result is drained while a new request is accepted in the same cycle. On that edge the register must switch straight to the new value without passing through an empty state. The bench reaches it by driving `out_ready` from a pseudo-random sequence while requests keep arriving. This produces many stall runs, and each stall ends on an edge that also accepts fresh input. A 4-bit instance is swept over every code and every operand pair in both modes, so each bit lane sees all four operand-bit combinations under each function.

// File: rtl/mask_tt_pkg.sv
package mask_tt_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    OP_CLEAR = 4'd0,
    OP_SET   = 4'd1,
    OP_CPY_A = 4'd2,
    OP_CPY_B = 4'd3,
    OP_NOT_A = 4'd4,
    OP_NOT_B = 4'd5,
    OP_ANDN  = 4'd6,
    OP_ORN   = 4'd7,
    OP_XORN  = 4'd8,
    OP_AND   = 4'd9,
    OP_OR    = 4'd10,
    OP_XOR   = 4'd11
  } named_op_e;

  // truth-table codes, indexed by {a_bit, b_bit}
  localparam logic [CODE_W-1:0] TT_ZERO  = 4'h0;
  localparam logic [CODE_W-1:0] TT_ONES  = 4'hF;
  localparam logic [CODE_W-1:0] TT_A     = 4'hC;
  localparam logic [CODE_W-1:0] TT_B     = 4'hA;
  localparam logic [CODE_W-1:0] TT_NA    = 4'h3;
  localparam logic [CODE_W-1:0] TT_NB    = 4'h5;
  localparam logic [CODE_W-1:0] TT_ANDN  = 4'h4;
  localparam logic [CODE_W-1:0] TT_ORN   = 4'hD;
  localparam logic [CODE_W-1:0] TT_XORN  = 4'h9;
  localparam logic [CODE_W-1:0] TT_AND   = 4'h8;
  localparam logic [CODE_W-1:0] TT_OR    = 4'hE;
  localparam logic [CODE_W-1:0] TT_XOR   = 4'h6;
endpackage

// File: rtl/mask_tt_code_map.sv
module mask_tt_code_map
  import mask_tt_pkg::*;
(
  input  logic              named,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] table_code
);
  logic [CODE_W-1:0] mapped;

  always_comb begin
    case (code)
      OP_CLEAR: mapped = TT_ZERO;
      OP_SET:   mapped = TT_ONES;
      OP_CPY_A: mapped = TT_A;
      OP_CPY_B: mapped = TT_B;
      OP_NOT_A: mapped = TT_NA;
      OP_NOT_B: mapped = TT_NB;
      OP_ANDN:  mapped = TT_ANDN;
      OP_ORN:   mapped = TT_ORN;
      OP_XORN:  mapped = TT_XORN;
      OP_AND:   mapped = TT_AND;
      OP_OR:    mapped = TT_OR;
      OP_XOR:   mapped = TT_XOR;
      default:  mapped = TT_ZERO;
    endcase
  end

  assign table_code = named ? mapped : code;
endmodule

// File: rtl/mask_tt_lanes.sv
module mask_tt_lanes
  import mask_tt_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [CODE_W-1:0] table_code,
  input  logic [W-1:0]      src_a,
  input  logic [W-1:0]      src_b,
  output logic [W-1:0]      result
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    logic [1:0] sel;
    assign sel       = {src_a[i], src_b[i]};
    assign result[i] = table_code[sel];
  end
endmodule

// File: rtl/mask_tt_out_stage.sv
module mask_tt_out_stage #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] next_result,
  input  logic         drain,
  output logic         full,
  output logic [W-1:0] result
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full   <= 1'b0;
      result <= '0;
    end else if (load) begin
      full   <= 1'b1;
      result <= next_result;
    end else if (drain) begin
      full   <= 1'b0;
    end
  end
endmodule

// File: rtl/mask_tt_unit.sv
module mask_tt_unit
  import mask_tt_pkg::*;
#(
  parameter int W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_named,
  input  logic [CODE_W-1:0] in_code,
  input  logic [W-1:0]      in_src1,
  input  logic [W-1:0]      in_src2,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_result
);
  logic [CODE_W-1:0] table_code;
  logic [W-1:0]      lane_result;
  logic              accept;
  logic              drain;

  assign drain    = out_valid && out_ready;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  mask_tt_code_map u_map (
    .named      (in_named),
    .code       (in_code),
    .table_code (table_code)
  );

  mask_tt_lanes #(.W(W)) u_lanes (
    .table_code (table_code),
    .src_a      (in_src1),
    .src_b      (in_src2),
    .result     (lane_result)
  );

  mask_tt_out_stage #(.W(W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .load        (accept),
    .next_result (lane_result),
    .drain       (drain),
    .full        (out_valid),
    .result      (out_result)
  );
endmodule

// File: rtl/mask_tt_unit_chk.sv
module mask_tt_unit_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_named,
  input logic [3:0]   in_code,
  input logic [W-1:0] in_src1,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_result == '0));

  // R6
  accept_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  // R8
  idle_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && (!out_valid || out_ready)) |=> !out_valid);

  // R3
  raw_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_named && in_code == 4'h0) |=> (out_result == '0));

  // R4
  named_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_named && in_code == 4'd2) |=> (out_result == $past(in_src1)));
endmodule

bind mask_tt_unit mask_tt_unit_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_named   (in_named),
  .in_code    (in_code),
  .in_src1    (in_src1),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result)
);

// File: tb/mask_tt_unit_test.sv
`timescale 1ns/1ps
module mask_tt_unit_test;
  localparam int W = 4;
  localparam int TOTAL = 8192;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_named = 1'b0;
  logic [3:0]   in_code = '0;
  logic [W-1:0] in_src1 = '0;
  logic [W-1:0] in_src2 = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_result;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mask_tt_unit #(.W(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_named(in_named), .in_code(in_code), .in_src1(in_src1), .in_src2(in_src2),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // sum of minterms: each code bit contributes its operand combination
  function automatic logic [W-1:0] raw_expect(input logic [3:0] c, input logic [W-1:0] a,
                                              input logic [W-1:0] b);
    logic [W-1:0] r = '0;
    if (c[0]) r = r | (~a & ~b);
    if (c[1]) r = r | (~a & b);
    if (c[2]) r = r | (a & ~b);
    if (c[3]) r = r | (a & b);
    return r;
  endfunction

  function automatic logic [W-1:0] named_expect(input logic [3:0] c, input logic [W-1:0] a,
                                                input logic [W-1:0] b);
    case (c)
      4'd0:  return '0;
      4'd1:  return '1;
      4'd2:  return a;
      4'd3:  return b;
      4'd4:  return ~a;
      4'd5:  return ~b;
      4'd6:  return a & ~b;
      4'd7:  return a | ~b;
      4'd8:  return a ^ ~b;
      4'd9:  return a & b;
      4'd10: return a | b;
      4'd11: return a ^ b;
      default: return '0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, TOTAL);
    finish_run();
  end

  initial begin
    logic [W-1:0] expq[$];
    string        tagq[$];
    logic [15:0]  lfsr = 16'hACE1;
    int           idx = 0;
    bit           stalled = 0;
    logic [W-1:0] held = '0;
    bit           acc_prev = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid && out_result == '0, "R1 reset state", out_result, '0);
    rst = 1'b0;

    while (idx < TOTAL || expq.size() != 0 || in_valid) begin
      @(negedge clk);
      check(out_valid == (expq.size() != 0), "R8 out_valid tracks pending",
            {{(W-1){1'b0}}, out_valid}, {{(W-1){1'b0}}, expq.size() != 0});
      if (acc_prev)
        check(out_valid, "R6 one-cycle latency", {{(W-1){1'b0}}, out_valid}, 1);
      if (stalled)
        check(out_valid && out_result == held, "R7 held during stall", out_result, held);

      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[1];
      if (!in_valid || acc_prev || idx == 0) begin
        if (idx < TOTAL && lfsr[2] | lfsr[3] | lfsr[4]) begin
          in_valid = 1'b1;
          in_named = idx[12];
          in_code  = idx[11:8];
          in_src1  = idx[7:4];
          in_src2  = idx[3:0];
          idx++;
        end else begin
          in_valid = 1'b0;
        end
      end
      #1;
      if (out_valid && !out_ready)
        check(!in_ready, "R7 in_ready low during stall", {{(W-1){1'b0}}, in_ready}, 0);
      else
        check(in_ready, "R8 in_ready high", {{(W-1){1'b0}}, in_ready}, 1);

      if (out_valid && out_ready) begin
        check(out_result == expq[0], tagq[0], out_result, expq[0]);
        void'(expq.pop_front());
        void'(tagq.pop_front());
      end
      acc_prev = in_valid && in_ready;
      if (acc_prev) begin
        if (!in_named) begin
          expq.push_back(raw_expect(in_code, in_src1, in_src2));
          tagq.push_back((in_code == 4'h0 || in_code == 4'hF) ? "R3 raw clear/set" : "R2 raw truth table");
        end else begin
          expq.push_back(named_expect(in_code, in_src1, in_src2));
          tagq.push_back(in_code >= 4'd12 ? "R5 unused named index" : "R4 named op");
        end
      end
      stalled = out_valid && !out_ready;
      held = out_result;
    end

    // mid-stream reset with a result pending
    @(negedge clk);
    in_valid = 1'b1; in_named = 1'b0; in_code = 4'hF; in_src1 = '0; in_src2 = '0;
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_result == '1, "R3 set before reset", out_result, '1);
    rst = 1'b1;
    @(negedge clk);
    check(!out_valid && out_result == '0, "R1 reset clears pending", out_result, '0);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid, "R8 stays empty", {{(W-1){1'b0}}, out_valid}, 0);
    finish_run();
  end
endmodule